// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block runs the multi-cycle hand-over between a processor core and its interrupt service routines. A request comes from the interrupt controller as a vector index with a valid/ready handshake. The sequencer accepts it only at an instruction boundary. It then saves the current program counter as two bytes on a downward-growing byte stack and loads the vector address into the program counter. If the core was asleep when the request was accepted, a fixed wake-up interval runs first.

A return request is also taken at an instruction boundary. The sequencer pops the two saved bytes in reverse order, reloads the program counter and raises the global interrupt enable. While either sequence runs, `busy` stalls instruction fetch. The rest of the status register is left to software.

Back-pressure: `irq_ready` depends only on the sequencer being idle, the boundary strobe and the absence of a return request. It never depends on `irq_valid`. A request is taken in the cycle where `irq_valid` and `irq_ready` are both high. The requester must hold `irq_valid` and `irq_vec` stable until that cycle.

Top module: `irq_seq_top`

## Requirements
- R1: After reset `busy`, `irq_ready` (while `insn_done` is low), `stk_we`, `stk_re`, `pc_load`, `gie_clr` and `gie_set` are low, and `sp` equals the parameter `SP_RST`.
- R2: `irq_ready` is high only when the sequencer is idle, `insn_done` is high and `reti_req` is low. A request with `insn_done` low is held: nothing starts and `busy` stays low.
- R3: An entry accepted while `asleep` is low keeps `busy` high for exactly 4 cycles after the handshake cycle. `pc_load` is high in the fourth of those cycles only.
- R4: An entry accepted while `asleep` is high keeps `busy` high for `WAKE_CYC` (default 4) extra cycles before the 4 entry cycles. No stack access happens during the wake interval.
- R5: In entry cycle 1 the block writes the low program-counter byte at address `sp`. In entry cycle 2 it writes the high byte at `sp-1`. Each write decrements `sp`, so `sp` ends 2 lower.
- R6: The address loaded at the end of entry equals `irq_vec * SLOT_WORDS`.
- R7: `gie_clr` pulses for exactly one cycle, the first busy cycle after an entry handshake. It pulses at no other time.
- R8: A return keeps `busy` high for 4 cycles. Cycle 1 reads address `sp+1` and cycle 2 reads `sp+2`, with `sp` rising by one after each read. In cycle 4 `pc_load` is high with `pc_load_val` = {first byte read, second byte read}. `sp` ends 2 higher.
- R9: `gie_set` pulses only in the fourth return cycle, together with `pc_load`.
- R10: When `reti_req` and `irq_valid` are both high at an idle boundary, the return runs first and the request stays pending. The request can be accepted at a later boundary.
- R11: While `busy` is high, `irq_ready` stays low and `insn_done` and `reti_req` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_valid | input | 1 | Interrupt request valid |
| irq_vec | input | VEC_W | Vector index of the request |
| irq_ready | output | 1 | Request accepted when high with irq_valid |
| insn_done | input | 1 | Current instruction completes this cycle |
| asleep | input | 1 | Core is in a sleep state |
| reti_req | input | 1 | Return-from-interrupt at this boundary |
| pc_cur | input | PC_W | Return address to save |
| pc_load | output | 1 | Load pc_load_val into the program counter |
| pc_load_val | output | PC_W | Vector or restored return address |
| busy | output | 1 | Sequence running; stall fetch |
| gie_clr | output | 1 | Clear global interrupt enable |
| gie_set | output | 1 | Set global interrupt enable |
| stk_we | output | 1 | Stack byte write |
| stk_re | output | 1 | Stack byte read; data valid next cycle |
| stk_addr | output | SP_W | Stack byte address |
| stk_wdata | output | 8 | Byte to write |
| stk_rdata | input | 8 | Byte read, registered one cycle after stk_re |
| sp | output | SP_W | Current stack pointer |

## Verification
If the phase or wake counter goes wrong, `busy` ends one cycle early or late, or `pc_load` appears in the wrong cycle. This shows within a single entry or return. A wrong stack pointer or byte order shows as a bad `stk_addr` in the first push. It also shows as a restored address different from the one saved, at the end of the matching return. With nested entries the error shows by the second return. A wrong handshake condition shows in the same cycle as a high `irq_ready` while `busy` is high or a return is requested.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_WAKE  = 2'd1,
    SQ_ENTER = 2'd2,
    SQ_LEAVE = 2'd3
  } sq_state_e;

  localparam int unsigned SQ_PHASES = 4;
endpackage

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm
  import irq_seq_pkg::*;
#(
  parameter int unsigned WAKE_CYC = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      irq_valid,
  input  logic      insn_done,
  input  logic      asleep,
  input  logic      reti_req,
  output sq_state_e state,
  output logic [1:0] phase,
  output logic      can_take,
  output logic      accept,
  output logic      ret_start
);
  localparam int unsigned WCW = (WAKE_CYC > 1) ? $clog2(WAKE_CYC) : 1;
  localparam bit WAKE_EN = (WAKE_CYC > 0);
  localparam logic [WCW-1:0] WLAST = WCW'(WAKE_EN ? WAKE_CYC - 1 : 0);
  localparam logic [1:0] PLAST = 2'(SQ_PHASES - 1);

  logic [WCW-1:0] wcnt;

  // Boundary arbitration: a return request wins over a pending interrupt.
  assign can_take  = (state == SQ_IDLE) && insn_done && !reti_req;
  assign accept    = can_take && irq_valid;
  assign ret_start = (state == SQ_IDLE) && insn_done && reti_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SQ_IDLE;
      phase <= '0;
      wcnt  <= '0;
    end else begin
      unique case (state)
        SQ_IDLE: begin
          phase <= '0;
          wcnt  <= '0;
          if (ret_start)
            state <= SQ_LEAVE;
          else if (accept)
            state <= (asleep && WAKE_EN) ? SQ_WAKE : SQ_ENTER;
        end
        SQ_WAKE: begin
          if (wcnt == WLAST) begin
            state <= SQ_ENTER;
            wcnt  <= '0;
          end else begin
            wcnt <= wcnt + 1'b1;
          end
        end
        SQ_ENTER, SQ_LEAVE: begin
          if (phase == PLAST) begin
            state <= SQ_IDLE;
            phase <= '0;
          end else begin
            phase <= phase + 1'b1;
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/irq_seq_stack.sv
module irq_seq_stack #(
  parameter int unsigned    SP_W   = 8,
  parameter logic [SP_W-1:0] SP_RST = '1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic            pop,
  output logic [SP_W-1:0] sp,
  output logic [SP_W-1:0] sp_up
);
  // Downward stack: push writes at sp then decrements;
  // pop increments then reads at the new sp (addressed as sp+1 beforehand).
  assign sp_up = sp + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      sp <= SP_RST;
    else if (push)
      sp <= sp - 1'b1;
    else if (pop)
      sp <= sp_up;
  end
endmodule

// File: rtl/irq_seq_path.sv
module irq_seq_path #(
  parameter int unsigned PC_W       = 16,
  parameter int unsigned VEC_W      = 4,
  parameter int unsigned SLOT_WORDS = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic [VEC_W-1:0] irq_vec,
  input  logic [PC_W-1:0]  pc_cur,
  input  logic             hi_cap,
  input  logic             lo_cap,
  input  logic             sel_high,
  input  logic [7:0]       rdata,
  output logic [7:0]       push_byte,
  output logic [PC_W-1:0]  vec_addr,
  output logic [PC_W-1:0]  ret_addr
);
  localparam int unsigned HI_W = PC_W - 8;

  logic [PC_W-1:0]  pc_q;
  logic [VEC_W-1:0] vec_q;
  logic [HI_W-1:0]  hi_q;
  logic [7:0]       lo_q;
  logic [15:0]      pc_ext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      vec_q <= '0;
      hi_q  <= '0;
      lo_q  <= '0;
    end else begin
      if (accept) begin
        pc_q  <= pc_cur;
        vec_q <= irq_vec;
      end
      if (hi_cap) hi_q <= rdata[HI_W-1:0];
      if (lo_cap) lo_q <= rdata;
    end
  end

  assign pc_ext    = 16'(pc_q);
  assign push_byte = sel_high ? pc_ext[15:8] : pc_ext[7:0];
  assign vec_addr  = PC_W'(vec_q) * PC_W'(SLOT_WORDS);
  assign ret_addr  = {hi_q, lo_q};
endmodule

// File: rtl/irq_seq_top.sv
module irq_seq_top
  import irq_seq_pkg::*;
#(
  parameter int unsigned     PC_W       = 16,
  parameter int unsigned     SP_W       = 8,
  parameter int unsigned     VEC_W      = 4,
  parameter int unsigned     SLOT_WORDS = 1,
  parameter int unsigned     WAKE_CYC   = 4,
  parameter logic [SP_W-1:0] SP_RST     = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             irq_valid,
  input  logic [VEC_W-1:0] irq_vec,
  output logic             irq_ready,
  input  logic             insn_done,
  input  logic             asleep,
  input  logic             reti_req,
  input  logic [PC_W-1:0]  pc_cur,
  output logic             pc_load,
  output logic [PC_W-1:0]  pc_load_val,
  output logic             busy,
  output logic             gie_clr,
  output logic             gie_set,
  output logic             stk_we,
  output logic             stk_re,
  output logic [SP_W-1:0]  stk_addr,
  output logic [7:0]       stk_wdata,
  input  logic [7:0]       stk_rdata,
  output logic [SP_W-1:0]  sp
);
  sq_state_e  state;
  logic [1:0] phase;
  logic       can_take, accept, ret_start;
  logic       in_enter, in_leave, acc_q;
  logic [SP_W-1:0] sp_up;
  logic [PC_W-1:0] vec_addr, ret_addr;

  irq_seq_fsm #(.WAKE_CYC(WAKE_CYC)) u_fsm (
    .clk(clk), .rst_n(rst_n), .irq_valid(irq_valid), .insn_done(insn_done),
    .asleep(asleep), .reti_req(reti_req), .state(state), .phase(phase),
    .can_take(can_take), .accept(accept), .ret_start(ret_start)
  );

  assign in_enter = (state == SQ_ENTER);
  assign in_leave = (state == SQ_LEAVE);

  irq_seq_stack #(.SP_W(SP_W), .SP_RST(SP_RST)) u_stack (
    .clk(clk), .rst_n(rst_n),
    .push(in_enter && !phase[1]),
    .pop(in_leave && !phase[1]),
    .sp(sp), .sp_up(sp_up)
  );

  irq_seq_path #(.PC_W(PC_W), .VEC_W(VEC_W), .SLOT_WORDS(SLOT_WORDS)) u_path (
    .clk(clk), .rst_n(rst_n), .accept(accept), .irq_vec(irq_vec),
    .pc_cur(pc_cur),
    .hi_cap(in_leave && phase == 2'd1),
    .lo_cap(in_leave && phase == 2'd2),
    .sel_high(phase[0]), .rdata(stk_rdata),
    .push_byte(stk_wdata), .vec_addr(vec_addr), .ret_addr(ret_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= 1'b0;
    else        acc_q <= accept;
  end

  assign irq_ready   = can_take;
  assign busy        = (state != SQ_IDLE);
  assign gie_clr     = acc_q;
  assign gie_set     = in_leave && phase == 2'd3;
  assign stk_we      = in_enter && !phase[1];
  assign stk_re      = in_leave && !phase[1];
  assign stk_addr    = in_leave ? sp_up : sp;
  assign pc_load     = (in_enter || in_leave) && phase == 2'd3;
  assign pc_load_val = in_leave ? ret_addr : vec_addr;
endmodule

// File: rtl/irq_seq_chk.sv
module irq_seq_chk #(
  parameter int unsigned SP_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            irq_valid,
  input logic            irq_ready,
  input logic            reti_req,
  input logic            busy,
  input logic            gie_clr,
  input logic            gie_set,
  input logic            pc_load,
  input logic            stk_we,
  input logic            stk_re,
  input logic [SP_W-1:0] stk_addr
);
  // R11
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ready |-> !busy && !reti_req);

  // R7
  gie_clr_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_ready) |=> gie_clr && busy);

  // R7
  gie_clr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gie_clr |=> !gie_clr);

  // R9
  gie_set_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gie_set |-> pc_load && busy);

  // R3
  load_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |=> !busy);

  // R5
  push_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stk_we) |=> stk_we && (stk_addr == SP_W'($past(stk_addr) - 1'b1)));

  // R8
  pop_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stk_re) |=> stk_re && (stk_addr == SP_W'($past(stk_addr) + 1'b1)));

  // R4
  access_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(stk_we && stk_re));
endmodule

bind irq_seq_top irq_seq_chk #(.SP_W(SP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_valid(irq_valid), .irq_ready(irq_ready),
  .reti_req(reti_req), .busy(busy), .gie_clr(gie_clr), .gie_set(gie_set),
  .pc_load(pc_load), .stk_we(stk_we), .stk_re(stk_re), .stk_addr(stk_addr)
);

// File: tb/sim_irq_seq_top.sv
module sim_irq_seq_top;
  localparam int unsigned PC_W = 16, SP_W = 8, VEC_W = 4, SLOT = 2, WAKE = 4;
  localparam logic [7:0] SPR = 8'hFF;

  logic clk = 1'b0, rst_n = 1'b0;
  logic irq_valid = 0, insn_done = 0, asleep = 0, reti_req = 0;
  logic [VEC_W-1:0] irq_vec = '0;
  logic [PC_W-1:0]  pc_cur = '0;
  logic irq_ready, pc_load, busy, gie_clr, gie_set, stk_we, stk_re;
  logic [PC_W-1:0] pc_load_val;
  logic [SP_W-1:0] stk_addr, sp;
  logic [7:0] stk_wdata, stk_rdata;
  logic [7:0] mem [256];

  int n_tests = 0, n_fail = 0;
  logic [7:0] sp_m;
  logic [15:0] saved [$];
  logic [15:0] pc_gen;

  always #5 clk = ~clk;

  irq_seq_top #(.PC_W(PC_W), .SP_W(SP_W), .VEC_W(VEC_W), .SLOT_WORDS(SLOT),
                .WAKE_CYC(WAKE), .SP_RST(SPR)) u0 (
    .clk(clk), .rst_n(rst_n), .irq_valid(irq_valid), .irq_vec(irq_vec),
    .irq_ready(irq_ready), .insn_done(insn_done), .asleep(asleep),
    .reti_req(reti_req), .pc_cur(pc_cur), .pc_load(pc_load),
    .pc_load_val(pc_load_val), .busy(busy), .gie_clr(gie_clr),
    .gie_set(gie_set), .stk_we(stk_we), .stk_re(stk_re), .stk_addr(stk_addr),
    .stk_wdata(stk_wdata), .stk_rdata(stk_rdata), .sp(sp)
  );

  always @(posedge clk) begin
    if (stk_we) mem[stk_addr] <= stk_wdata;
    if (stk_re) stk_rdata <= mem[stk_addr];
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  // Entry with handshake at the current negedge; boundary stays high while busy (R11).
  task automatic do_entry(input logic [3:0] v, input logic [15:0] p, input bit slp);
    irq_valid = 1; irq_vec = v; pc_cur = p; asleep = slp; insn_done = 1;
    #1 chk("R2 ready at boundary", irq_ready, 1);
    tick();
    pc_cur = ~p;
    if (slp) begin
      for (int k = 0; k < WAKE; k++) begin
        chk("R4 busy wake", busy, 1);
        chk("R4 no stack access in wake", {stk_we, stk_re, pc_load}, 0);
        chk("R7 gie_clr wake", gie_clr, (k == 0));
        chk("R11 ready low", irq_ready, 0);
        tick();
      end
    end
    for (int k = 0; k < 4; k++) begin
      chk("R3 busy entry", busy, 1);
      chk("R11 ready low", irq_ready, 0);
      chk("R7 gie_clr entry", gie_clr, (k == 0 && !slp));
      chk("R5 write strobe", stk_we, (k < 2));
      if (k == 0) begin
        chk("R5 low byte addr", stk_addr, sp_m);
        chk("R5 low byte data", stk_wdata, p[7:0]);
      end
      if (k == 1) begin
        chk("R5 high byte addr", stk_addr, sp_m - 8'd1);
        chk("R5 high byte data", stk_wdata, p[15:8]);
      end
      chk("R3 pc_load slot", pc_load, (k == 3));
      if (k == 3) chk("R6 vector", pc_load_val, v * SLOT);
      tick();
    end
    irq_valid = 0; insn_done = 0; asleep = 0;
    sp_m = sp_m - 8'd2;
    chk("R3 busy drops", busy, 0);
    chk("R5 sp after push", sp, sp_m);
    saved.push_back(p);
  endtask

  task automatic do_return();
    logic [15:0] exp_pc;
    exp_pc = saved.pop_back();
    reti_req = 1; insn_done = 1;
    #1 chk("R10 ready low on return", irq_ready, 0);
    tick();
    reti_req = 0;
    for (int k = 0; k < 4; k++) begin
      chk("R8 busy return", busy, 1);
      chk("R11 ready low", irq_ready, 0);
      chk("R8 read strobe", stk_re, (k < 2));
      chk("R8 no write", stk_we, 0);
      if (k == 0) chk("R8 first read addr", stk_addr, sp_m + 8'd1);
      if (k == 1) chk("R8 second read addr", stk_addr, sp_m + 8'd2);
      chk("R9 gie_set slot", gie_set, (k == 3));
      chk("R7 no gie_clr", gie_clr, 0);
      if (k == 3) begin
        chk("R8 pc_load", pc_load, 1);
        chk("R8 restored pc", pc_load_val, exp_pc);
      end
      tick();
    end
    insn_done = 0;
    sp_m = sp_m + 8'd2;
    chk("R8 busy drops", busy, 0);
    chk("R8 sp after pop", sp, sp_m);
  endtask

  initial begin
    fork
      begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
      end
    join_none
    sp_m = SPR;
    repeat (3) @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 strobes", {irq_ready, stk_we, stk_re, pc_load, gie_clr, gie_set}, 0);
    chk("R1 sp", sp, SPR);
    rst_n = 1;
    tick();
    chk("R1 idle after release", busy, 0);

    // R2: request held off until the instruction boundary
    irq_valid = 1; irq_vec = 4'd7; insn_done = 0;
    for (int k = 0; k < 5; k++) begin
      #1 chk("R2 no ready mid instruction", irq_ready, 0);
      tick();
      chk("R2 nothing started", busy, 0);
    end
    irq_valid = 0;

    // Sweep every vector, awake and asleep, each followed by its return
    for (int s = 0; s < 2; s++)
      for (int v = 0; v < 16; v++) begin
        pc_gen = 16'h1357 + 16'(v) * 16'h0F1D + 16'(s) * 16'h8000;
        do_entry(4'(v), pc_gen, s[0]);
        tick();
        do_return();
        tick();
      end

    // Nesting: three entries then three returns (LIFO order, R5/R8)
    do_entry(4'd2, 16'hA1B2, 1'b0);
    do_entry(4'd9, 16'h0C3D, 1'b1);
    do_entry(4'd15, 16'hFFEE, 1'b0);
    // R10: return and request at the same boundary, return first
    irq_valid = 1; irq_vec = 4'd4;
    do_return();
    chk("R10 request still pending", irq_valid & ~busy, 1);
    do_entry(4'd4, 16'h5A5A, 1'b0);
    do_return();
    do_return();
    do_return();
    chk("R8 sp back at reset value", sp, SPR);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule